// File: doc/BRIEF.md
# Trimmed Real-Time Clock Prescaler

This block turns a 32768 Hz low-frequency clock into a one-second timebase. A first divide-by-256 stage feeds a second 7-bit stage, which wraps once per nominal second and marks each wrap with a one-cycle tick. A fine digital trim corrects for crystal error. A 6-bit magnitude and a direction bit set how many second-stage steps are suppressed or boosted inside each correction window. The nominal window is one hour, and its length is a parameter.

The corrections are not applied in one burst. The window is split into 64 equal slots. Slot `j` carries one correction when the bit-reversed slot index is below the magnitude. This spreads the corrections evenly over the window. When the block is in counter mode, the trim is ignored.

A 2-bit select drives a calibration output for frequency measurement. The choices are silent, 512 Hz, 256 Hz, or the second-stage MSB, which runs at 1 Hz.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While `rst_ni` is low, `sec_div_o` is 0, `tick_1hz_o` is 0 and `cal_clk_o` is 0.
- R2: With a magnitude of 0, `sec_div_o` advances by one every 256 clocks. Over a window of `WIN_CYCLES` clocks it advances by `WIN_CYCLES/256`, modulo 128.
- R3: With `trim_up_i` = 0 and magnitude N in calendar mode, N second-stage steps per window are held. The window's total advance is `WIN_CYCLES/256 - N`.
- R4: With `trim_up_i` = 1 and magnitude N, N second-stage steps per window advance by 3 instead of 1. The window's total advance is `WIN_CYCLES/256 + 2N`. No single step exceeds 3.
- R5: The window has 64 slots of `WIN_CYCLES/64` clocks. Slot j carries a correction when the 6-bit reversal of j is below N. After the first half of a window, exactly ceil(N/2) corrections have been applied.
- R6: The magnitude and direction are sampled only on the first clock of a window. A change during a window has no effect until the next window.
- R7: With `cal_mode_i` = 0 (counter mode), no correction is applied. Every step is exactly +1.
- R8: `tick_1hz_o` is high for exactly one cycle, in the cycle where `sec_div_o` has wrapped past 127. Per window, the number of ticks equals floor((start value + advance)/128).
- R9: `cal_sel_i` encoding: 2'b00 holds `cal_clk_o` low. 2'b01 gives a square wave of period 64 clocks (512 Hz). 2'b10 gives a square wave of period 128 clocks (256 Hz). 2'b11 gives `sec_div_o[6]`, delayed one cycle.
- R10: A magnitude of 0 applies no correction with `trim_up_i` at either value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32768 Hz low-frequency clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| trim_mag_i | input | 6 | Trim magnitude, corrections per window |
| trim_up_i | input | 1 | Trim direction: 1 = speed up, 0 = slow down |
| cal_sel_i | input | 2 | Calibration output select |
| cal_mode_i | input | 1 | 1 = calendar mode (trim active), 0 = counter mode |
| tick_1hz_o | output | 1 | One-cycle pulse on each second-stage wrap |
| cal_clk_o | output | 1 | Calibration clock output |
| sec_div_o | output | 7 | Second-stage counter value |

## Verification
The second-stage counter and the tick update on the same edge as a first-stage terminal count. A window that starts on clock edge 1 therefore has its last step on its final edge. The monitor samples on the falling edge after edge WIN/2 and after edge WIN, where the expected mid-window and end-of-window values are due.

The calibration output is registered, so it lags its source by one cycle. The bench compares the 1 Hz choice against the counter value it saw one cycle earlier. For the square-wave choices it counts rising edges over whole windows.

Inputs change 1 ns after a falling edge. This gives the window-start sampling of R6 an input that is stable on its edge.

// File: rtl/rtc_trim_pkg.sv
`timescale 1ns/1ps
package rtc_trim_pkg;
  typedef enum logic [1:0] {
    CAL_OFF  = 2'b00,
    CAL_FAST = 2'b01,
    CAL_HALF = 2'b10,
    CAL_SEC  = 2'b11
  } cal_sel_e;

  localparam logic [1:0] STEP_HOLD  = 2'd0;
  localparam logic [1:0] STEP_NORM  = 2'd1;
  localparam logic [1:0] STEP_BOOST = 2'd3;
endpackage

// File: rtl/rtc_div_stage1.sv
`timescale 1ns/1ps
module rtc_div_stage1 #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = &cnt_q;
endmodule

// File: rtl/rtc_trim_sched.sv
`timescale 1ns/1ps
module rtc_trim_sched #(
  parameter int unsigned TRIM_W   = 6,
  parameter int unsigned SLOT_LEN = 1843200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIM_W-1:0] trim_mag_i,
  input  logic              trim_up_i,
  input  logic              cal_mode_i,
  input  logic              step_i,
  output logic              fire_o,
  output logic              up_o
);
  localparam int unsigned SLOT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);

  logic [SLOT_W-1:0] slot_cnt_q, slot_cnt_d;
  logic [TRIM_W-1:0] slot_idx_q, slot_idx_d;
  logic [TRIM_W-1:0] mag_q, mag_d;
  logic              up_q, up_d;
  logic              pend_q, pend_d;
  logic [TRIM_W-1:0] slot_rev;
  logic              slot_start, win_start, slot_end, slot_hit;

  for (genvar b = 0; b < TRIM_W; b++) begin : g_rev
    assign slot_rev[b] = slot_idx_q[TRIM_W-1-b];
  end

  always_comb begin
    slot_start = (slot_cnt_q == '0);
    win_start  = slot_start && (slot_idx_q == '0);
    slot_end   = (slot_cnt_q == SLOT_LAST);

    slot_cnt_d = slot_end ? '0 : slot_cnt_q + 1'b1;
    slot_idx_d = slot_end ? slot_idx_q + 1'b1 : slot_idx_q;

    mag_d = win_start ? trim_mag_i : mag_q;
    up_d  = win_start ? trim_up_i  : up_q;

    slot_hit = (slot_rev < mag_d);

    if (slot_start)  pend_d = slot_hit;
    else if (step_i) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      slot_idx_q <= '0;
      mag_q      <= '0;
      up_q       <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      slot_cnt_q <= slot_cnt_d;
      slot_idx_q <= slot_idx_d;
      mag_q      <= mag_d;
      up_q       <= up_d;
      pend_q     <= pend_d;
    end
  end

  assign fire_o = pend_q & step_i & cal_mode_i;
  assign up_o   = up_q;
endmodule

// File: rtl/rtc_div_stage2.sv
`timescale 1ns/1ps
module rtc_div_stage2
  import rtc_trim_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         fire_i,
  input  logic         up_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d;
  logic [1:0]   inc;
  logic [W:0]   sum;

  always_comb begin
    if (fire_i) inc = up_i ? STEP_BOOST : STEP_HOLD;
    else        inc = STEP_NORM;
    sum    = {1'b0, cnt_q} + (W+1)'(inc);
    cnt_d  = step_i ? sum[W-1:0] : cnt_q;
    wrap_d = step_i & sum[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/rtc_cal_mux.sv
`timescale 1ns/1ps
module rtc_cal_mux
  import rtc_trim_pkg::*;
#(
  parameter int unsigned S1_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      sel_i,
  input  logic [S1_W-1:0] s1_cnt_i,
  input  logic            s2_msb_i,
  output logic            cal_o
);
  localparam int unsigned FAST_BIT = S1_W - 3;
  localparam int unsigned HALF_BIT = S1_W - 2;

  logic cal_q, cal_d;

  always_comb begin
    unique case (cal_sel_e'(sel_i))
      CAL_FAST: cal_d = s1_cnt_i[FAST_BIT];
      CAL_HALF: cal_d = s1_cnt_i[HALF_BIT];
      CAL_SEC:  cal_d = s2_msb_i;
      default:  cal_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= 1'b0;
    else         cal_q <= cal_d;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/rtc_trim_prescaler.sv
`timescale 1ns/1ps
module rtc_trim_prescaler #(
  parameter int unsigned S1_W       = 8,
  parameter int unsigned S2_W       = 7,
  parameter int unsigned TRIM_W     = 6,
  parameter int unsigned WIN_CYCLES = 117964800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIM_W-1:0] trim_mag_i,
  input  logic              trim_up_i,
  input  logic [1:0]        cal_sel_i,
  input  logic              cal_mode_i,
  output logic              tick_1hz_o,
  output logic              cal_clk_o,
  output logic [S2_W-1:0]   sec_div_o
);
  localparam int unsigned SLOTS    = 2 ** TRIM_W;
  localparam int unsigned SLOT_LEN = WIN_CYCLES / SLOTS;

  logic [S1_W-1:0] s1_cnt;
  logic            s1_tc;
  logic            fire, up;

  rtc_div_stage1 #(.W(S1_W)) i_stage1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (s1_cnt),
    .tc_o   (s1_tc)
  );

  rtc_trim_sched #(.TRIM_W(TRIM_W), .SLOT_LEN(SLOT_LEN)) i_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trim_mag_i (trim_mag_i),
    .trim_up_i  (trim_up_i),
    .cal_mode_i (cal_mode_i),
    .step_i     (s1_tc),
    .fire_o     (fire),
    .up_o       (up)
  );

  rtc_div_stage2 #(.W(S2_W)) i_stage2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (s1_tc),
    .fire_i (fire),
    .up_i   (up),
    .cnt_o  (sec_div_o),
    .wrap_o (tick_1hz_o)
  );

  rtc_cal_mux #(.S1_W(S1_W)) i_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (cal_sel_i),
    .s1_cnt_i (s1_cnt),
    .s2_msb_i (sec_div_o[S2_W-1]),
    .cal_o    (cal_clk_o)
  );
endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
`timescale 1ns/1ps
module rtc_trim_prescaler_chk #(
  parameter int unsigned S2_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      cal_sel_i,
  input logic            cal_mode_i,
  input logic            tick_1hz_o,
  input logic            cal_clk_o,
  input logic [S2_W-1:0] sec_div_o
);
  logic [S2_W-1:0] prev_q;
  logic [S2_W-1:0] delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sec_div_o;
  end

  assign delta = sec_div_o - prev_q;

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (sec_div_o == '0 && !tick_1hz_o && !cal_clk_o));

  assert_step_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delta <= S2_W'(3));

  assert_counter_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cal_mode_i) |-> delta <= S2_W'(1));

  assert_tick_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |-> sec_div_o < prev_q);

  assert_wrap_has_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_1hz_o |-> sec_div_o >= prev_q);

  assert_tick_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_1hz_o |=> !tick_1hz_o);

  assert_cal_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cal_sel_i) == 2'b00) |-> !cal_clk_o);

  assert_cal_sec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cal_sel_i) == 2'b11) |-> cal_clk_o == prev_q[S2_W-1]);
endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(.S2_W(S2_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cal_sel_i  (cal_sel_i),
  .cal_mode_i (cal_mode_i),
  .tick_1hz_o (tick_1hz_o),
  .cal_clk_o  (cal_clk_o),
  .sec_div_o  (sec_div_o)
);

// File: tb/test_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module test_rtc_trim_prescaler;
  localparam int WIN  = 16384;
  localparam int HALF = WIN / 2;
  localparam int EV   = WIN / 256;
  localparam int NWIN = 7;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] trim_mag = '0;
  logic       trim_up = 1'b0;
  logic [1:0] cal_sel = 2'b00;
  logic       cal_mode = 1'b1;
  logic       tick;
  logic       cal_clk;
  logic [6:0] sec_div;

  always #2 clk = ~clk;

  rtc_trim_prescaler #(.WIN_CYCLES(WIN)) i_rtc_trim_prescaler (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .trim_mag_i (trim_mag),
    .trim_up_i  (trim_up),
    .cal_sel_i  (cal_sel),
    .cal_mode_i (cal_mode),
    .tick_1hz_o (tick),
    .cal_clk_o  (cal_clk),
    .sec_div_o  (sec_div)
  );

  typedef struct {
    int    exp_cnt;
    int    exp_ticks;
    bit    is_end;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    total = 0;
  int    bad = 0;
  int    model_cnt = 0;
  int    cur_sel = 0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int advance(input int n, input bit up, input bit cal, input bit half);
    int base;
    int c;
    base = half ? EV / 2 : EV;
    c = half ? (n + 1) / 2 : n;
    if (!cal) c = 0;
    return up ? base + 2 * c : base - c;
  endfunction

  // Called 1 ns after a falling edge; returns 1 ns after the falling edge ending the window.
  task automatic drive_window(input int n, input bit up, input bit cal, input int sel,
                              input bit glitch, input string tag);
    exp_t m;
    exp_t e;
    int   adv;
    trim_mag = 6'(n);
    trim_up  = up;
    cal_mode = cal;
    cal_sel  = 2'(sel);
    cur_sel  = sel;
    adv = advance(n, up, cal, 1'b0);
    m.exp_cnt   = (model_cnt + advance(n, up, cal, 1'b1)) % 128;
    m.exp_ticks = 0;
    m.is_end    = 1'b0;
    m.tag       = "R5 mid-window";
    e.exp_cnt   = (model_cnt + adv) % 128;
    e.exp_ticks = (model_cnt + adv) / 128;
    e.is_end    = 1'b1;
    e.tag       = tag;
    sb_q.push_back(m);
    sb_q.push_back(e);
    model_cnt = (model_cnt + adv) % 128;
    repeat (HALF) @(negedge clk);
    #1;
    if (glitch) begin
      trim_mag = 6'((n + 35) % 64);
      trim_up  = ~up;
    end
    repeat (HALF) @(negedge clk);
    #1;
  endtask

  task automatic monitor();
    exp_t it;
    int   ticks;
    int   pulse_bad;
    int   rises;
    int   mism;
    int   sel;
    bit   prev_tick;
    bit   prev_cal;
    int   prev_s2;
    prev_tick = 1'b0;
    prev_cal  = 1'b0;
    prev_s2   = 0;
    for (int w = 0; w < NWIN; w++) begin
      ticks = 0;
      pulse_bad = 0;
      rises = 0;
      mism = 0;
      sel = -1;
      for (int i = 0; i < WIN; i++) begin
        @(negedge clk);
        if (i == 0) sel = cur_sel;
        if (tick) ticks++;
        if (tick && prev_tick) pulse_bad++;
        if (cal_clk && !prev_cal) rises++;
        if (sel == 0 && cal_clk) mism++;
        if (sel == 3 && (cal_clk != prev_s2[6])) mism++;
        prev_tick = tick;
        prev_cal  = cal_clk;
        prev_s2   = int'(sec_div);
        if (i == HALF - 1 || i == WIN - 1) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "scoreboard empty", 0, 1);
          end else begin
            it = sb_q.pop_front();
            check(int'(sec_div) == it.exp_cnt, it.tag, int'(sec_div), it.exp_cnt);
            if (it.is_end)
              check(ticks == it.exp_ticks, "R8 tick count", ticks, it.exp_ticks);
          end
        end
      end
      check(pulse_bad == 0, "R8 tick width", pulse_bad, 0);
      case (sel)
        1:       check(rises == WIN / 64, "R9 512 Hz edges", rises, WIN / 64);
        2:       check(rises == WIN / 128, "R9 256 Hz edges", rises, WIN / 128);
        default: check(mism == 0, "R9 off or 1 Hz mismatches", mism, 0);
      endcase
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(sec_div == 7'd0, "R1 counter in reset", int'(sec_div), 0);
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(cal_clk == 1'b0, "R1 cal in reset", int'(cal_clk), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    fork
      monitor();
      begin
        #1;
        drive_window(0,  1'b0, 1'b1, 1, 1'b0, "R2 nominal");
        drive_window(5,  1'b0, 1'b1, 2, 1'b1, "R6 slow with mid-window change");
        drive_window(20, 1'b1, 1'b1, 3, 1'b0, "R4 speed up");
        drive_window(63, 1'b1, 1'b1, 0, 1'b0, "R4 full-scale speed up");
        drive_window(30, 1'b1, 1'b0, 1, 1'b0, "R7 counter mode");
        drive_window(0,  1'b1, 1'b1, 2, 1'b0, "R10 zero magnitude up");
        drive_window(1,  1'b0, 1'b1, 3, 1'b0, "R3 slow down");
      end
    join
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule